// File: doc/BRIEF.md
# Audio AGC Gain Step Controller

This block drives the digital attenuation setting of a mono audio amplifier. The analog front end asserts a single flag, `over_lvl`, while the output would clip or go past the programmed level limit. The block answers by adding attenuation one half-decibel step at a time, up to a fixed floor. Once the flag drops, it takes the attenuation back off one step at a time. Level detection, distortion measurement and supply sensing stay outside the block and reach it only through that flag.

Three minimum-spacing rules gate every step, and all three are counted in pulses of an internal prescaled tick:
- **Attack:** the gap between two gain reductions.
- **Hold:** the gap from the latest reduction to the next restoration.
- **Release:** the gap between two restorations.

A base gain of 12 dB or 18 dB is chosen by one input. The total gain output is that base minus the present attenuation, in half-decibel units. Clearing the enable holds the gain at its base.

Top module: `agc_gain_stepper`

## Requirements
- R1: While `agc_en` is high, every change of `atten_steps` from one clock edge to the next is exactly +1 or -1, which is one 0.5 dB step.
- R2: `atten_steps` never exceeds MAX_STEPS (30 by default, which is 15 dB). With `atten_steps` at MAX_STEPS and `over_lvl` high, it stays at MAX_STEPS.
- R3: An increase of `atten_steps` (a gain cut) needs ATTACK_TICKS tick pulses counted after the edge of the previous cut. When that holds and `over_lvl` is high below the floor, the cut lands on the next clock edge.
- R4: A decrease of `atten_steps` (a gain restore) needs HOLD_TICKS tick pulses counted after the edge of the most recent cut.
- R5: A restore needs RELEASE_TICKS tick pulses counted after the edge of the previous restore. When R4 and R5 are both met, `over_lvl` is low and `atten_steps` is nonzero, the restore lands on the next clock edge.
- R6: `gain_hdb` is a two's-complement value in 0.5 dB units, equal to the base minus `atten_steps`. `base_hi` = 0 selects BASE_LO_HDB (24, which is 12 dB) and `base_hi` = 1 selects BASE_HI_HDB (36, which is 18 dB). It follows `base_hi` without a clock delay.
- R7: With `agc_en` low at a clock edge, `atten_steps` is 0 after that edge and remains 0 whatever `over_lvl` does. The prescaler and all spacing timers return to their idle state.
- R8: Synchronous active-high `rst` clears `atten_steps` to 0 and leaves every spacing timer satisfied. The first edge after reset with `agc_en` and `over_lvl` high therefore already cuts by one step.
- R9: The tick fires once per TICK_DIV consecutive enabled cycles, first on the TICK_DIV-th enabled cycle after reset or re-enable. The ticks are the only thing that advances the spacing timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| agc_en | input | 1 | Gain control enable; low forces zero attenuation |
| over_lvl | input | 1 | High while the output would clip or exceed the level limit |
| base_hi | input | 1 | Base gain select: 0 = 12 dB, 1 = 18 dB |
| atten_steps | output | AW (5) | Present attenuation in 0.5 dB steps |
| gain_hdb | output | GW (8) | Signed total gain in 0.5 dB units |

## Verification
The bench uses the default floor of 30 steps with a prescaler of 3 and spacings of 2, 5 and 3 ticks. This puts a full descent to the floor, and the complete climb back, within a few hundred cycles. Within that configuration the bench sweeps the flag, the base select, the enable and reset through long pseudo-random segments. Every cycle is compared against an arithmetic timing model. The sweep reaches every attenuation value under both bases, including negative total gain, and varies the prescaler phase against each spacing rule.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // Decision taken by the step controller in one cycle.
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_CUT  = 2'd1,   // one more step of attenuation
        MOVE_LIFT = 2'd2    // one step of attenuation removed
    } move_e;

    // Index of each spacing timer.
    localparam int unsigned SPAN_ATTACK  = 0;
    localparam int unsigned SPAN_HOLD    = 1;
    localparam int unsigned SPAN_RELEASE = 2;
    localparam int unsigned SPAN_N       = 3;

    // Bits needed to hold the values 0..v.
    function automatic int unsigned cwidth(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/agc_tick_gen.sv
module agc_tick_gen #(
    parameter int unsigned DIV = 37
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            // Every enabled cycle is a tick.
            assign tick = en;
        end else begin : g_div
            localparam int unsigned CW = agc_pkg::cwidth(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] phase;
            } tick_st_t;

            tick_st_t st_d, st_q;
            logic     wrap;

            assign wrap = (st_q.phase == CW'(DIV - 1));

            always_comb begin
                st_d = st_q;
                if (!en || wrap) begin
                    st_d.phase = '0;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick = en && wrap;

            // R9
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/agc_span_timer.sv
module agc_span_timer #(
    parameter int unsigned LIMIT = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic restart,
    output logic ok
);

    localparam int unsigned CW = agc_pkg::cwidth(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } span_st_t;

    span_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = LIM;
        end else if (restart) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != LIM)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= LIM;
        end else begin
            st_q <= st_d;
        end
    end

    assign ok = (st_q.cnt == LIM);

    // R3, R4, R5
    restart_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (en && restart) |=> !ok);

    // R8
    idle_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (ok && !restart) |=> ok);

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
    import agc_pkg::*;
#(
    parameter int unsigned MAX_STEPS = 30,
    parameter int unsigned AW        = cwidth(MAX_STEPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          over,
    input  logic          attack_ok,
    input  logic          hold_ok,
    input  logic          release_ok,
    output logic [AW-1:0] atten,
    output logic          cut,
    output logic          lift
);

    localparam logic [AW-1:0] FLOOR = AW'(MAX_STEPS);

    typedef struct packed {
        logic [AW-1:0] atten;
    } step_st_t;

    step_st_t st_d, st_q;
    move_e    mv;

    always_comb begin
        mv = MOVE_NONE;
        if (en) begin
            if (over) begin
                if ((st_q.atten != FLOOR) && attack_ok) begin
                    mv = MOVE_CUT;
                end
            end else if ((st_q.atten != '0) && hold_ok && release_ok) begin
                mv = MOVE_LIFT;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.atten = '0;
        end else begin
            case (mv)
                MOVE_CUT:  st_d.atten = st_q.atten + 1'b1;
                MOVE_LIFT: st_d.atten = st_q.atten - 1'b1;
                default:   st_d.atten = st_q.atten;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign atten = st_q.atten;
    assign cut   = (mv == MOVE_CUT);
    assign lift  = (mv == MOVE_LIFT);

    // R2
    floor_limit_chk: assert property (@(posedge clk) disable iff (rst)
        atten <= FLOOR);

    // R2
    floor_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (en && over && (atten == FLOOR)) |=> (atten == FLOOR));

    // R1
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> ((atten == $past(atten)) ||
                (atten == $past(atten) + 1'b1) ||
                (atten + 1'b1 == $past(atten))));

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (atten == '0));

endmodule

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
    import agc_pkg::*;
#(
    parameter  int unsigned TICK_DIV      = 37,
    parameter  int unsigned ATTACK_TICKS  = 11,
    parameter  int unsigned HOLD_TICKS    = 4333,
    parameter  int unsigned RELEASE_TICKS = 4333,
    parameter  int unsigned MAX_STEPS     = 30,
    parameter  int unsigned BASE_LO_HDB   = 24,
    parameter  int unsigned BASE_HI_HDB   = 36,
    localparam int unsigned AW            = cwidth(MAX_STEPS),
    localparam int unsigned GW            = cwidth(BASE_HI_HDB + MAX_STEPS) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 agc_en,
    input  logic                 over_lvl,
    input  logic                 base_hi,
    output logic [AW-1:0]        atten_steps,
    output logic signed [GW-1:0] gain_hdb
);

    localparam int unsigned SPAN_LIM [SPAN_N] = '{ATTACK_TICKS, HOLD_TICKS, RELEASE_TICKS};

    logic              tick;
    logic              cut;
    logic              lift;
    logic [SPAN_N-1:0] span_restart;
    logic [SPAN_N-1:0] span_ok;

    agc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (agc_en),
        .tick (tick)
    );

    // Attack and hold both count from the last cut; release counts from the last lift.
    assign span_restart[SPAN_ATTACK]  = cut;
    assign span_restart[SPAN_HOLD]    = cut;
    assign span_restart[SPAN_RELEASE] = lift;

    generate
        for (genvar g = 0; g < SPAN_N; g++) begin : g_span
            agc_span_timer #(.LIMIT(SPAN_LIM[g])) u_span (
                .clk     (clk),
                .rst     (rst),
                .en      (agc_en),
                .tick    (tick),
                .restart (span_restart[g]),
                .ok      (span_ok[g])
            );
        end
    endgenerate

    agc_step_ctrl #(.MAX_STEPS(MAX_STEPS), .AW(AW)) u_step (
        .clk        (clk),
        .rst        (rst),
        .en         (agc_en),
        .over       (over_lvl),
        .attack_ok  (span_ok[SPAN_ATTACK]),
        .hold_ok    (span_ok[SPAN_HOLD]),
        .release_ok (span_ok[SPAN_RELEASE]),
        .atten      (atten_steps),
        .cut        (cut),
        .lift       (lift)
    );

    logic signed [GW-1:0] base_s;

    always_comb begin
        base_s   = base_hi ? GW'(BASE_HI_HDB) : GW'(BASE_LO_HDB);
        gain_hdb = base_s - signed'({{(GW-AW){1'b0}}, atten_steps});
    end

    // Spacing monitor: counts ticks since a change seen on the attenuation output.
    localparam int unsigned MON_MAX = max3(ATTACK_TICKS, HOLD_TICKS, RELEASE_TICKS);
    localparam int unsigned MW      = cwidth(MON_MAX);

    logic [AW-1:0] seen_q;
    logic [MW-1:0] since_cut_q;
    logic [MW-1:0] since_lift_q;
    logic          rose;
    logic          fell;

    assign rose = (atten_steps > seen_q);
    assign fell = (atten_steps < seen_q);

    always_ff @(posedge clk) begin
        if (rst || !agc_en) begin
            seen_q       <= '0;
            since_cut_q  <= MW'(MON_MAX);
            since_lift_q <= MW'(MON_MAX);
        end else begin
            seen_q <= atten_steps;
            if (rose) begin
                since_cut_q <= tick ? MW'(1) : '0;
            end else if (tick && (since_cut_q != MW'(MON_MAX))) begin
                since_cut_q <= since_cut_q + 1'b1;
            end
            if (fell) begin
                since_lift_q <= tick ? MW'(1) : '0;
            end else if (tick && (since_lift_q != MW'(MON_MAX))) begin
                since_lift_q <= since_lift_q + 1'b1;
            end
        end
    end

    // R3
    attack_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rose |-> ($past(since_cut_q) >= MW'(ATTACK_TICKS)));

    // R4
    hold_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fell |-> ($past(since_cut_q) >= MW'(HOLD_TICKS)));

    // R5
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fell |-> ($past(since_lift_q) >= MW'(RELEASE_TICKS)));

endmodule

// File: tb/tb_agc_gain_stepper.sv
module tb_agc_gain_stepper;

    localparam int DIV   = 3;
    localparam int ATT   = 2;
    localparam int HOLD  = 5;
    localparam int REL   = 3;
    localparam int MAXS  = 30;
    localparam int BLO   = 24;
    localparam int BHI   = 36;
    localparam int AW    = 5;
    localparam int GW    = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst = 1'b1;
    logic en = 1'b0;
    logic flag = 1'b0;
    logic sel = 1'b1;
    logic [AW-1:0] atten;
    logic signed [GW-1:0] gain;

    agc_gain_stepper #(
        .TICK_DIV(DIV), .ATTACK_TICKS(ATT), .HOLD_TICKS(HOLD),
        .RELEASE_TICKS(REL), .MAX_STEPS(MAXS),
        .BASE_LO_HDB(BLO), .BASE_HI_HDB(BHI)
    ) dut (
        .clk(clk), .rst(rst), .agc_en(en), .over_lvl(flag), .base_hi(sel),
        .atten_steps(atten), .gain_hdb(gain)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Timing model built from R3, R4, R5, R7, R8, R9.
    int lim [3] = '{ATT, HOLD, REL};
    int m_presc = 0;
    int m_cnt [3] = '{ATT, HOLD, REL};
    int m_att = 0;

    always @(posedge clk) begin
        bit t, c, l;
        if (rst || !en) begin
            m_presc = 0;
            for (int i = 0; i < 3; i++) m_cnt[i] = lim[i];
            m_att = 0;
        end else begin
            t = (m_presc == DIV - 1);
            c = flag && (m_att < MAXS) && (m_cnt[0] == lim[0]);
            l = !flag && (m_att > 0) && (m_cnt[1] == lim[1]) && (m_cnt[2] == lim[2]);
            m_presc = t ? 0 : m_presc + 1;
            for (int i = 0; i < 3; i++) begin
                if ((i < 2 && c) || (i == 2 && l)) m_cnt[i] = 0;
                else if (t && m_cnt[i] < lim[i]) m_cnt[i] = m_cnt[i] + 1;
            end
            m_att = m_att + int'(c) - int'(l);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int cyc = 0;
    int prev_att = 0;
    bit prev_ok = 0;
    int last_rise = -1;
    int last_fall = -1;

    // One clock; checks taken at the falling edge, before inputs change.
    task automatic step();
        int a, g, base;
        @(negedge clk);
        cyc++;
        a = int'(atten);
        g = int'(gain);
        base = sel ? BHI : BLO;
        check(a == m_att, "R3 R4 R5 R9 attenuation vs timing model", a, m_att);
        check(g == base - m_att, "R6 gain equals base minus attenuation", g, base - m_att);
        check(a <= MAXS, "R2 attenuation within floor", a, MAXS);
        if (rst || !en) begin
            check(a == 0, "R7 R8 attenuation cleared", a, 0);
            last_rise = -1;
            last_fall = -1;
        end else begin
            if (prev_ok)
                check((a - prev_att <= 1) && (prev_att - a <= 1), "R1 single step", a, prev_att);
            if (prev_ok && a == prev_att + 1) begin
                if (last_rise >= 0)
                    check(cyc - last_rise >= (ATT - 1) * DIV + 2, "R3 cut spacing",
                          cyc - last_rise, (ATT - 1) * DIV + 2);
                last_rise = cyc;
            end
            if (prev_ok && a == prev_att - 1) begin
                if (last_rise >= 0)
                    check(cyc - last_rise >= (HOLD - 1) * DIV + 2, "R4 hold spacing",
                          cyc - last_rise, (HOLD - 1) * DIV + 2);
                if (last_fall >= 0)
                    check(cyc - last_fall >= (REL - 1) * DIV + 2, "R5 release spacing",
                          cyc - last_fall, (REL - 1) * DIV + 2);
                last_fall = cyc;
            end
        end
        prev_att = a;
        prev_ok = 1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;

        repeat (3) step();
        check(atten == 0, "R8 reset attenuation", int'(atten), 0);
        check(gain == BHI, "R6 reset gain high base", int'(gain), BHI);

        // R8: first cut is not delayed after reset
        rst = 1'b0; en = 1'b1; flag = 1'b1;
        step();
        check(atten == 1, "R8 first cut on first edge", int'(atten), 1);

        // R2: descend to the floor and stay there
        repeat (250) step();
        check(atten == MAXS, "R2 floor reached", int'(atten), MAXS);
        check(gain == BHI - MAXS, "R6 gain at floor", int'(gain), BHI - MAXS);
        repeat (50) step();
        check(atten == MAXS, "R2 floor held under request", int'(atten), MAXS);
        sel = 1'b0;
        step();
        check(gain == BLO - MAXS, "R6 negative total gain", int'(gain), BLO - MAXS);

        // R4 R5: full climb back
        flag = 1'b0;
        repeat (400) step();
        check(atten == 0, "R5 full release", int'(atten), 0);

        // Pseudo-random sweep over flag, base, enable and reset
        for (int s = 0; s < 150; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            flag = lfsr[0];
            sel = lfsr[5];
            en = (lfsr[3:1] != 3'd0);
            if (lfsr[9:6] == 4'd0) begin
                rst = 1'b1;
                step();
                rst = 1'b0;
            end
            repeat (23) step();
        end

        // R7: disable clears and blocks steps
        rst = 1'b0; en = 1'b1; flag = 1'b1;
        repeat (30) step();
        en = 1'b0;
        step();
        check(atten == 0, "R7 disable clears", int'(atten), 0);
        for (int k = 0; k < 20; k++) begin
            flag = k[1];
            step();
            check(atten == 0, "R7 no steps while disabled", int'(atten), 0);
        end

        // R8: reset mid-run, then immediate cut
        en = 1'b1; flag = 1'b1;
        repeat (40) step();
        rst = 1'b1;
        step();
        check(atten == 0, "R8 reset clears mid-run", int'(atten), 0);
        rst = 1'b0;
        step();
        check(atten == 1, "R8 timers idle after reset", int'(atten), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule